// File: doc/BRIEF.md
# Saturating Load Percentage Meter

This block estimates how hard a switching converter is working. It counts activity pulses from the power stage, such as one pulse for each switching cycle that reached the current limit, over a fixed measurement window. At the end of each window it scales the count against a programmable full-scale count. The result is a load figure in percent of the converter's capability, presented as a 7-bit value that never exceeds 100.

The window is a parameterised number of time-base ticks. After the meter is enabled, the first window only warms the meter up and its count is discarded. The first result therefore follows the second window end, and each later window gives a fresh result. Each result comes from a short bit-serial divider that finishes well inside the next window. A one-cycle strobe marks each new result, and a valid flag reports that a result exists. Clearing the enable stops all measurement. It also returns the output to zero.

Top module: `load_pct_meter`

## Requirements
- R1: While `en_i` is low, and at reset, `pct_o` is 0, `valid_o` is 0 and `upd_o` is 0. Disabling also abandons any result in progress, so that result is never published.
- R2: A published result equals floor(C × 100 / F). C is the activity count of the window and F is `full_scale_i` as sampled at the window end. The result is an unsigned 7-bit value.
- R3: When C ≥ F, the result is exactly 100. This includes F = 0. No published value is ever above 100.
- R4: The first window after `en_i` rises produces no result. The first result comes from the second window end.
- R5: After the first result, every window end produces a new result, and each result depends only on the pulses of its own window.
- R6: A window closes on the WIN_TICKS-th cycle after enable, or after the previous window end, in which `tick_i` is high. An `act_i` pulse in that same cycle is counted in the closing window.
- R7: `valid_o` is low from enable until the first result and high afterwards while enabled. `pct_o` changes only in the cycle in which `upd_o` is high.
- R8: `upd_o` is high for exactly one cycle per result. It rises, together with the new `pct_o`, after the seventh rising edge that follows the edge that samples the closing tick.
- R9: The per-window activity count saturates at 2^CNT_W − 1 instead of wrapping.
- R10: With WIN_TICKS ≥ 8, a divide never overlaps a window end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Meter enable; low clears and holds the meter |
| tick_i | input | 1 | Time-base tick, one cycle per tick |
| act_i | input | 1 | Activity pulse from the power stage |
| full_scale_i | input | CNT_W | Count per window that corresponds to 100 % load |
| pct_o | output | 7 | Load in percent, 0 to 100 |
| valid_o | output | 1 | A result has been published since enable |
| upd_o | output | 1 | One-cycle strobe for each new result |

## Verification
Two things can fall in the same cycle: the tick that closes a window, and an activity pulse that must still count toward that window. The bench drives activity in every cycle, and at random in others, while ticks arrive on fixed and random spacings, so closing ticks often coincide with pulses. A bench model charges each such pulse to the closing window, computes the expected percentage independently, and compares it cycle by cycle with the published result. Disables that arrive during a divide are checked the same way: no strobe may appear afterwards.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int PCT_W    = 7;
  localparam int PCT_FULL = 100;
  localparam int QBITS    = 7;
  localparam int DIV_LAT  = 7;
endpackage

// File: rtl/lpm_window.sv
module lpm_window #(
  parameter int WIN_TICKS = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  output logic win_end_o,
  output logic warm_o
);
  localparam int WW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;

  logic [WW-1:0] tick_cnt;
  logic          last_tick;

  assign last_tick = (tick_cnt == WW'(WIN_TICKS - 1));
  assign win_end_o = en_i & tick_i & last_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      warm_o   <= 1'b0;
    end else if (!en_i) begin
      tick_cnt <= '0;
      warm_o   <= 1'b0;
    end else if (tick_i) begin
      tick_cnt <= last_tick ? '0 : tick_cnt + 1'b1;
      if (last_tick) warm_o <= 1'b1;
    end
  end
endmodule

// File: rtl/lpm_act_counter.sv
module lpm_act_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             act_i,
  input  logic             win_end_i,
  output logic [CNT_W-1:0] cap_o
);
  logic [CNT_W-1:0] cnt;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c, input logic a);
    return (a && (c != {CNT_W{1'b1}})) ? c + 1'b1 : c;
  endfunction

  assign cap_o = sat_inc(cnt, act_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!en_i || win_end_i) cnt <= '0;
    else                       cnt <= cap_o;
  end
endmodule

// File: rtl/lpm_divider.sv
module lpm_divider
  import lpm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] fs_i,
  output logic             busy_o,
  output logic [PCT_W-1:0] pct_o,
  output logic             valid_o,
  output logic             upd_o
);
  localparam int NW = CNT_W + QBITS;

  logic [NW-1:0]    rem;
  logic [CNT_W-1:0] fs_q;
  logic [2:0]       bit_idx;
  logic [QBITS-1:0] quo;
  logic             sat_q;
  logic [NW-1:0]    trial;
  logic             take;
  logic [QBITS-1:0] quo_next;

  function automatic logic [NW-1:0] times100(input logic [CNT_W-1:0] c);
    return (NW'(c) << 6) + (NW'(c) << 5) + (NW'(c) << 2);
  endfunction

  function automatic logic saturates(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] f);
    return (f == '0) || (c >= f);
  endfunction

  assign trial    = NW'(fs_q) << bit_idx;
  assign take     = (rem >= trial);
  assign quo_next = take ? (quo | (QBITS'(1) << bit_idx)) : quo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o  <= 1'b0;
      bit_idx <= '0;
      rem     <= '0;
      fs_q    <= '0;
      quo     <= '0;
      sat_q   <= 1'b0;
      pct_o   <= '0;
      valid_o <= 1'b0;
      upd_o   <= 1'b0;
    end else if (!en_i) begin
      busy_o  <= 1'b0;
      pct_o   <= '0;
      valid_o <= 1'b0;
      upd_o   <= 1'b0;
    end else begin
      upd_o <= 1'b0;
      if (start_i) begin
        busy_o  <= 1'b1;
        bit_idx <= 3'(QBITS - 1);
        rem     <= times100(cnt_i);
        fs_q    <= fs_i;
        quo     <= '0;
        sat_q   <= saturates(cnt_i, fs_i);
      end else if (busy_o) begin
        if (take) rem <= rem - trial;
        quo <= quo_next;
        if (bit_idx == 3'd0) begin
          busy_o  <= 1'b0;
          pct_o   <= sat_q ? PCT_W'(PCT_FULL) : quo_next;
          valid_o <= 1'b1;
          upd_o   <= 1'b1;
        end else begin
          bit_idx <= bit_idx - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/load_pct_meter.sv
module load_pct_meter
  import lpm_pkg::*;
#(
  parameter int WIN_TICKS = 250,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             act_i,
  input  logic [CNT_W-1:0] full_scale_i,
  output logic [PCT_W-1:0] pct_o,
  output logic             valid_o,
  output logic             upd_o
);
  logic             win_end;
  logic             warm;
  logic             div_start;
  logic             div_busy;
  logic [CNT_W-1:0] win_count;

  lpm_window #(.WIN_TICKS(WIN_TICKS)) u_window (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_i(tick_i),
    .win_end_o(win_end), .warm_o(warm)
  );

  lpm_act_counter #(.CNT_W(CNT_W)) u_act (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .act_i(act_i),
    .win_end_i(win_end), .cap_o(win_count)
  );

  assign div_start = win_end & warm;

  lpm_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .start_i(div_start),
    .cnt_i(win_count), .fs_i(full_scale_i), .busy_o(div_busy),
    .pct_o(pct_o), .valid_o(valid_o), .upd_o(upd_o)
  );
endmodule

module lpm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic [6:0] pct_o,
  input logic       valid_o,
  input logic       upd_o,
  input logic       win_end,
  input logic       warm,
  input logic       div_busy
);
  AST_DISABLED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (pct_o == 7'd0 && !valid_o && !upd_o)); // R1
  AST_PCT_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
    pct_o <= 7'd100); // R3
  AST_WARMUP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !warm) |=> !div_busy); // R4
  AST_NO_DIV_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |-> !div_busy); // R10
  AST_UPD_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> valid_o); // R7
  AST_PCT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i ##1 (en_i && !upd_o)) |-> $stable(pct_o)); // R7
  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o); // R8
endmodule

bind load_pct_meter lpm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .pct_o(pct_o), .valid_o(valid_o),
  .upd_o(upd_o), .win_end(win_end), .warm(warm), .div_busy(div_busy)
);

// File: tb/load_pct_meter_tb.sv
module load_pct_meter_tb;
  localparam int WT   = 10;
  localparam int CW   = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en_i = 1'b0;
  logic          tick_i = 1'b0;
  logic          act_i = 1'b0;
  logic [CW-1:0] fs_i = '0;
  logic [6:0]    pct_o;
  logic          valid_o;
  logic          upd_o;

  int checks = 0;
  int errors = 0;
  int cyc_n = 0;
  int m_win = 0, m_act = 0, m_pend = 0, m_due = -1, m_pct = 0;
  bit m_warm = 0, m_valid = 0, m_upd = 0;
  string tag = "R1";

  load_pct_meter #(.WIN_TICKS(WT), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_i(tick_i), .act_i(act_i),
    .full_scale_i(fs_i), .pct_o(pct_o), .valid_o(valid_o), .upd_o(upd_o)
  );

  always #5 clk = ~clk;

  function automatic int exp_pct(int c, int f);
    int p;
    if (f == 0) return 100;
    p = (c * 100) / f;
    return (p > 100) ? 100 : p;
  endfunction

  task automatic compare(string t);
    checks++;
    if (upd_o !== m_upd) begin
      errors++;
      $display("FAIL %s R8 upd actual=%0b expected=%0b cycle=%0d", t, upd_o, m_upd, cyc_n);
    end else if (valid_o !== m_valid) begin
      errors++;
      $display("FAIL %s R7 valid actual=%0b expected=%0b cycle=%0d", t, valid_o, m_valid, cyc_n);
    end else if (int'(pct_o) != m_pct) begin
      errors++;
      $display("FAIL %s pct actual=%0d expected=%0d cycle=%0d", t, pct_o, m_pct, cyc_n);
    end
  endtask

  task automatic cyc(bit en, bit tk, bit ac);
    int nx;
    en_i = en; tick_i = tk; act_i = ac;
    @(posedge clk);
    cyc_n++;
    if (!en) begin
      m_win = 0; m_act = 0; m_warm = 0; m_due = -1;
      m_pct = 0; m_valid = 0; m_upd = 0;
    end else begin
      nx = (m_act + int'(ac) > CMAX) ? CMAX : m_act + int'(ac);
      if (tk && m_win == WT - 1) begin
        m_win = 0; m_act = 0;
        if (m_warm) begin
          m_due  = cyc_n + 7;
          m_pend = exp_pct(nx, int'(fs_i));
        end else m_warm = 1;
      end else begin
        if (tk) m_win++;
        m_act = nx;
      end
      m_upd = (m_due == cyc_n);
      if (m_upd) begin
        m_pct = m_pend; m_valid = 1; m_due = -1;
      end
    end
    #2;
    compare(tag);
  endtask

  task automatic run_dir(int n, int tper, bit act_on);
    for (int i = 0; i < n; i++) cyc(1'b1, (i % tper) == tper - 1, act_on);
  endtask

  task automatic restart();
    tag = "R1";
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int dis_left;
    int prob_act;
    int prob_tick;
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    #2;
    tag = "R1 reset";
    compare(tag);
    rst_n = 1'b1;
    restart();

    // R4: no result after the first window, only after the second
    tag = "R4 warmup"; fs_i = 6'd20;
    run_dir(3 * WT, 1, 1'b0);
    // R2: no activity reads 0
    tag = "R2 idle";
    run_dir(3 * WT, 1, 1'b0);

    // R3 boundary: count 20 == full scale 20 reads 100
    restart(); tag = "R3 exact"; fs_i = 6'd20;
    run_dir(3 * 2 * WT + 10, 2, 1'b1);
    // R2: 20 of 21 reads 95; R6 closing-cycle pulse counted
    restart(); tag = "R2 R6 scaled"; fs_i = 6'd21;
    run_dir(3 * 2 * WT + 10, 2, 1'b1);
    // R3: full scale 0 reads 100
    restart(); tag = "R3 zero fs"; fs_i = 6'd0;
    run_dir(3 * WT + 10, 1, 1'b0);

    // R9: 80 pulses saturate to 63
    restart(); tag = "R9 sat63"; fs_i = 6'd63;
    run_dir(3 * 8 * WT + 10, 8, 1'b1);
    restart(); tag = "R9 sat64"; fs_i = 6'd0;
    fs_i = 6'd40;
    run_dir(3 * 8 * WT + 10, 8, 1'b1);

    // R1: disable a few cycles after a window end, result must not appear
    restart(); tag = "R1 abort"; fs_i = 6'd10;
    run_dir(2 * WT, 1, 1'b1);
    cyc(1'b1, 1'b0, 1'b1);
    cyc(1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b0, 1'b1);

    // R5 R10: random load, tick spacing and full scale
    tag = "R5 R10 random";
    dis_left = 0; prob_act = 50; prob_tick = 40;
    for (int i = 0; i < 60000; i++) begin
      if (i % 500 == 0) prob_act = $urandom_range(0, 100);
      if (i % 900 == 0) prob_tick = $urandom_range(20, 100);
      if (i % 700 == 0) fs_i = CW'($urandom_range(0, CMAX));
      if (dis_left == 0 && $urandom_range(0, 799) == 0) dis_left = $urandom_range(1, 20);
      if (dis_left > 0) dis_left--;
      cyc(dis_left == 0, $urandom_range(0, 99) < prob_tick, $urandom_range(0, 99) < prob_act);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule